// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block counts hardware events for profiling. It has a set of event counters, four by default and 32 bits wide. Each counter has a programmable event selector. It also has one 48-bit cycle counter that a start event can arm and a stop event can disarm. The block watches a vector of single-cycle event pulses, one bit per event number. A counter advances on any clock where the pulse for its selected event is high, the global enable is set and the counter's own enable bit is set.

Software reaches the block through a simple synchronous register port: a write strobe, a byte address, write data and read data. Read data is a combinational function of the address and the current register state. Counter enables, overflow flags and overflow interrupt enables each sit behind a pair of write-one-to-act registers, one for set and one for clear, so that software never has to read, modify and write them. The monitor raises a level interrupt while any flagged overflow has its interrupt enable set.

Top module: `pmu_monitor`

## Requirements
- R1: After reset every readable register returns 0, the interrupt output is low, and the cycle counter is armed.
- R2: Event counter i adds one on each clock where the global enable is 1, enable bit i is 1, and bit n of the event vector is 1, where n is the counter's selector. A selector of 0, or one not below the number of event inputs (64), never counts.
- R3: Writing the enable-set register (0x184) sets the enable bits given by the 1s in the data. Writing the enable-clear register (0x188) clears them. Zero data bits change nothing. Reading 0x184 returns the mask. Only bits 0 to 3 (event counters) and bit 31 (cycle counter) exist, and all other bits read 0. Clear registers read 0.
- R4: In the control register (0x180), bit 0 is the global enable and reads back. Writing 1 to bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. Bits 1 and 2 always read 0. With the global enable at 0 no counter changes.
- R5: A counter that steps from all ones to zero sets its overflow bit, using the same bit positions as R3. Reading 0x18C returns the flags. Writes of 1s to 0x18C set flags, and writes of 1s to 0x190 clear them. When a hardware overflow and a clear write hit the same bit in the same clock, the flag ends up set.
- R6: The interrupt output is high exactly while some bit is set in both the overflow flags and the interrupt-enable mask. The mask is set through 0x194, cleared through 0x198, and read at 0x194.
- R7: The 48-bit cycle counter adds one per clock while the global enable, enable bit 31 and the armed state are all 1. Bits 31:0 read at 0x1A0. Bits 47:32 read at 0x1A4 in bits 15:0, with bits 31:16 reading 0. Wrapping past all ones sets overflow bit 31.
- R8: The configuration register at 0x1A8 holds the start event number in bits 9:0 and the stop event number in bits 25:16. A pulse of the start event arms the cycle counter from the next clock, and a pulse of the stop event disarms it. If both pulse together, the counter ends up disarmed. Event number 0 never pulses.
- R9: Each event counter is written directly at 0x300 + 4*i and its selector at 0x380 + 4*i (bits 9:0). The cycle counter halves are written at 0x1A0 and 0x1A4. A direct write overrides an increment in the same clock and never sets an overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| event_in | input | NUM_EVENTS (64) | Event pulses, bit n is event number n |
| irq | output | 1 | Level overflow interrupt |

## Verification
A wrong counter value, selector or armed state stays hidden until the affected register is read. It then appears as a mismatched word on reg_rdata, so the bench reads back every register in directed phases and reads random addresses throughout a long random phase. A wrong overflow flag or interrupt mask shows on irq in the same clock it takes effect, and irq is compared with the reference on every clock. An arming error shows up as a cycle count that drifts by one or more from the reference at the next read of the low word.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 32;

  // Control block, byte addresses
  localparam logic [ADDR_W-1:0] A_CTRL   = 10'h180;
  localparam logic [ADDR_W-1:0] A_ENSET  = 10'h184;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 10'h188;
  localparam logic [ADDR_W-1:0] A_OVSET  = 10'h18C;
  localparam logic [ADDR_W-1:0] A_OVCLR  = 10'h190;
  localparam logic [ADDR_W-1:0] A_IESET  = 10'h194;
  localparam logic [ADDR_W-1:0] A_IECLR  = 10'h198;
  localparam logic [ADDR_W-1:0] A_CYCLO  = 10'h1A0;
  localparam logic [ADDR_W-1:0] A_CYCHI  = 10'h1A4;
  localparam logic [ADDR_W-1:0] A_CYCCFG = 10'h1A8;

  // Per-counter arrays, 4-byte stride
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 10'h300;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 10'h380;

  // Control register bit positions
  localparam int unsigned CTL_EN      = 0;
  localparam int unsigned CTL_EVT_RST = 1;
  localparam int unsigned CTL_CYC_RST = 2;

  // Mask bit of the cycle counter
  localparam int unsigned CYC_BIT = 31;

  // Stop event field position in the configuration register
  localparam int unsigned STOP_LSB = 16;

  typedef struct packed {
    logic ctrl;
    logic enset;
    logic enclr;
    logic ovset;
    logic ovclr;
    logic ieset;
    logic ieclr;
    logic cyclo;
    logic cychi;
    logic cyccfg;
  } pmu_wdec_t;

endpackage

// File: rtl/pmu_event_match.sv
module pmu_event_match #(
  parameter int unsigned EVT_W      = 10,
  parameter int unsigned NUM_EVENTS = 64
) (
  input  logic [NUM_EVENTS-1:0] event_in,
  input  logic [EVT_W-1:0]      sel,
  output logic                  hit
);
  localparam int unsigned IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

  logic in_range;

  // Event number 0 is reserved as "no event"
  assign in_range = (sel != '0) && (32'(sel) < NUM_EVENTS);
  assign hit      = in_range && event_in[sel[IDX_W-1:0]];

endmodule

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg #(
  parameter int unsigned W         = 32,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;
  logic [W-1:0] q_next;

  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;

  // Hardware and software set both win over a same-cycle clear
  assign q_next = ((q & ~clr_bits) | set_bits | hw_set) & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned EVT_W      = 10,
  parameter int unsigned NUM_EVENTS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  count_en,
  input  logic [NUM_EVENTS-1:0] event_in,
  input  logic                  sel_we,
  input  logic [EVT_W-1:0]      sel_wdata,
  input  logic                  cnt_we,
  input  logic [CNT_W-1:0]      cnt_wdata,
  input  logic                  clr,
  output logic [CNT_W-1:0]      cnt,
  output logic [EVT_W-1:0]      sel,
  output logic                  wrap
);
  logic hit;
  logic inc;

  pmu_event_match #(
    .EVT_W      (EVT_W),
    .NUM_EVENTS (NUM_EVENTS)
  ) u_match (
    .event_in (event_in),
    .sel      (sel),
    .hit      (hit)
  );

  assign inc  = count_en && hit;
  // A direct write or a clear takes the counter away from the increment path
  assign wrap = inc && !cnt_we && !clr && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sel <= '0;
    end else begin
      if (sel_we) sel <= sel_wdata;
      if (cnt_we)      cnt <= cnt_wdata;
      else if (clr)    cnt <= '0;
      else if (inc)    cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int unsigned CYC_W      = 48,
  parameter int unsigned EVT_W      = 10,
  parameter int unsigned NUM_EVENTS = 64,
  localparam int unsigned HI_W      = CYC_W - 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  count_en,
  input  logic [NUM_EVENTS-1:0] event_in,
  input  logic                  cfg_we,
  input  logic [EVT_W-1:0]      start_wdata,
  input  logic [EVT_W-1:0]      stop_wdata,
  input  logic                  lo_we,
  input  logic [31:0]           lo_wdata,
  input  logic                  hi_we,
  input  logic [HI_W-1:0]       hi_wdata,
  input  logic                  clr,
  output logic [CYC_W-1:0]      cyc,
  output logic [EVT_W-1:0]      start_sel,
  output logic [EVT_W-1:0]      stop_sel,
  output logic                  wrap
);
  logic start_hit;
  logic stop_hit;
  logic armed_q;
  logic inc;
  logic sw_wr;

  pmu_event_match #(
    .EVT_W      (EVT_W),
    .NUM_EVENTS (NUM_EVENTS)
  ) u_start (
    .event_in (event_in),
    .sel      (start_sel),
    .hit      (start_hit)
  );

  pmu_event_match #(
    .EVT_W      (EVT_W),
    .NUM_EVENTS (NUM_EVENTS)
  ) u_stop (
    .event_in (event_in),
    .sel      (stop_sel),
    .hit      (stop_hit)
  );

  assign sw_wr = lo_we || hi_we;
  assign inc   = count_en && armed_q;
  assign wrap  = inc && !sw_wr && !clr && (cyc == '1);

  // Armed after reset; stop outranks start
  always_ff @(posedge clk) begin
    if (!rst_n)         armed_q <= 1'b1;
    else if (stop_hit)  armed_q <= 1'b0;
    else if (start_hit) armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_sel <= '0;
      stop_sel  <= '0;
    end else if (cfg_we) begin
      start_sel <= start_wdata;
      stop_sel  <= stop_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
    end else if (lo_we) begin
      cyc[31:0] <= lo_wdata;
    end else if (hi_we) begin
      cyc[CYC_W-1:32] <= hi_wdata;
    end else if (clr) begin
      cyc <= '0;
    end else if (inc) begin
      cyc <= cyc + 1'b1;
    end
  end

endmodule

// File: rtl/pmu_monitor.sv
module pmu_monitor #(
  parameter int unsigned NUM_CNT    = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned CYC_W      = 48,
  parameter int unsigned EVT_W      = 10,
  parameter int unsigned NUM_EVENTS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [pmu_pkg::ADDR_W-1:0] reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_EVENTS-1:0]      event_in,
  output logic                       irq
);
  import pmu_pkg::*;

  localparam int unsigned HI_W = CYC_W - 32;
  localparam logic [31:0] IMPL_MASK =
    (32'h1 << CYC_BIT) | ((32'h1 << NUM_CNT) - 32'h1);

  pmu_wdec_t wdec;

  logic                            gen_q;
  logic [31:0]                     en_q;
  logic [31:0]                     ov_q;
  logic [31:0]                     ie_q;
  logic [31:0]                     ov_hw;
  logic                            evt_clr;
  logic                            cyc_clr;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_q;
  logic [NUM_CNT-1:0][EVT_W-1:0]   sel_q;
  logic [NUM_CNT-1:0]              evt_wrap;
  logic [CYC_W-1:0]                cyc_q;
  logic [EVT_W-1:0]                start_q;
  logic [EVT_W-1:0]                stop_q;
  logic                            cyc_wrap;

  // Write decode for the fixed control block
  always_comb begin
    wdec        = '0;
    wdec.ctrl   = reg_wr && (reg_addr == A_CTRL);
    wdec.enset  = reg_wr && (reg_addr == A_ENSET);
    wdec.enclr  = reg_wr && (reg_addr == A_ENCLR);
    wdec.ovset  = reg_wr && (reg_addr == A_OVSET);
    wdec.ovclr  = reg_wr && (reg_addr == A_OVCLR);
    wdec.ieset  = reg_wr && (reg_addr == A_IESET);
    wdec.ieclr  = reg_wr && (reg_addr == A_IECLR);
    wdec.cyclo  = reg_wr && (reg_addr == A_CYCLO);
    wdec.cychi  = reg_wr && (reg_addr == A_CYCHI);
    wdec.cyccfg = reg_wr && (reg_addr == A_CYCCFG);
  end

  // Reset bits are one-shot strobes and are never stored
  assign evt_clr = wdec.ctrl && reg_wdata[CTL_EVT_RST];
  assign cyc_clr = wdec.ctrl && reg_wdata[CTL_CYC_RST];

  always_ff @(posedge clk) begin
    if (!rst_n)         gen_q <= 1'b0;
    else if (wdec.ctrl) gen_q <= reg_wdata[CTL_EN];
  end

  pmu_mask_reg #(.W(32), .IMPL_MASK(IMPL_MASK)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wdec.enset),
    .clr_we (wdec.enclr),
    .wdata  (reg_wdata),
    .hw_set (32'h0),
    .q      (en_q)
  );

  pmu_mask_reg #(.W(32), .IMPL_MASK(IMPL_MASK)) u_ov (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wdec.ovset),
    .clr_we (wdec.ovclr),
    .wdata  (reg_wdata),
    .hw_set (ov_hw),
    .q      (ov_q)
  );

  pmu_mask_reg #(.W(32), .IMPL_MASK(IMPL_MASK)) u_ie (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wdec.ieset),
    .clr_we (wdec.ieclr),
    .wdata  (reg_wdata),
    .hw_set (32'h0),
    .q      (ie_q)
  );

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    localparam logic [ADDR_W-1:0] CNT_ADDR = A_CNT_BASE + ADDR_W'(4 * gi);
    localparam logic [ADDR_W-1:0] SEL_ADDR = A_SEL_BASE + ADDR_W'(4 * gi);

    pmu_evt_counter #(
      .CNT_W      (CNT_W),
      .EVT_W      (EVT_W),
      .NUM_EVENTS (NUM_EVENTS)
    ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_en  (gen_q && en_q[gi]),
      .event_in  (event_in),
      .sel_we    (reg_wr && (reg_addr == SEL_ADDR)),
      .sel_wdata (reg_wdata[EVT_W-1:0]),
      .cnt_we    (reg_wr && (reg_addr == CNT_ADDR)),
      .cnt_wdata (reg_wdata[CNT_W-1:0]),
      .clr       (evt_clr),
      .cnt       (cnt_q[gi]),
      .sel       (sel_q[gi]),
      .wrap      (evt_wrap[gi])
    );
  end

  pmu_cycle_counter #(
    .CYC_W      (CYC_W),
    .EVT_W      (EVT_W),
    .NUM_EVENTS (NUM_EVENTS)
  ) u_cyc (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_en    (gen_q && en_q[CYC_BIT]),
    .event_in    (event_in),
    .cfg_we      (wdec.cyccfg),
    .start_wdata (reg_wdata[EVT_W-1:0]),
    .stop_wdata  (reg_wdata[STOP_LSB +: EVT_W]),
    .lo_we       (wdec.cyclo),
    .lo_wdata    (reg_wdata),
    .hi_we       (wdec.cychi),
    .hi_wdata    (reg_wdata[HI_W-1:0]),
    .clr         (cyc_clr),
    .cyc         (cyc_q),
    .start_sel   (start_q),
    .stop_sel    (stop_q),
    .wrap        (cyc_wrap)
  );

  always_comb begin
    ov_hw          = '0;
    ov_hw[NUM_CNT-1:0] = evt_wrap;
    ov_hw[CYC_BIT] = cyc_wrap;
  end

  assign irq = |(ov_q & ie_q);

  // Read mux; clear registers and holes read 0
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[CTL_EN] = gen_q;
      A_ENSET:  reg_rdata = en_q;
      A_OVSET:  reg_rdata = ov_q;
      A_IESET:  reg_rdata = ie_q;
      A_CYCLO:  reg_rdata = cyc_q[31:0];
      A_CYCHI:  reg_rdata[HI_W-1:0] = cyc_q[CYC_W-1:32];
      A_CYCCFG: begin
        reg_rdata[EVT_W-1:0]          = start_q;
        reg_rdata[STOP_LSB +: EVT_W]  = stop_q;
      end
      default:  reg_rdata = '0;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == (A_CNT_BASE + ADDR_W'(4 * i))) begin
        reg_rdata = '0;
        reg_rdata[CNT_W-1:0] = cnt_q[i];
      end
      if (reg_addr == (A_SEL_BASE + ADDR_W'(4 * i))) begin
        reg_rdata = '0;
        reg_rdata[EVT_W-1:0] = sel_q[i];
      end
    end
  end

endmodule

// File: rtl/pmu_monitor_chk.sv
module pmu_monitor_chk #(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CNT_W   = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic [pmu_pkg::ADDR_W-1:0] reg_addr,
  input logic                       evt_rst_bit,
  input logic [31:0]                reg_rdata,
  input logic                       irq,
  input logic                       gen_q,
  input logic [31:0]                ov_q,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
  import pmu_pkg::*;

  AST_EVT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && evt_rst_bit) |=> (cnt_q == '0)); // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_q && !reg_wr) |=> $stable(cnt_q)); // R4

  AST_CTRL_RESET_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[31:1] == '0)); // R4

  AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_OVCLR) |=> ((ov_q & $past(ov_q)) == $past(ov_q))); // R5

  AST_IRQ_NEEDS_OV: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ov_q != '0)); // R6

  AST_CYC_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CYCHI) |-> (reg_rdata[31:16] == '0)); // R7

  AST_UNIMPL_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_ENSET) |-> (reg_rdata[30:NUM_CNT] == '0)); // R3

  AST_CLR_REG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_ENCLR) |-> (reg_rdata == '0)); // R3

endmodule

bind pmu_monitor pmu_monitor_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .evt_rst_bit (reg_wdata[1]),
  .reg_rdata   (reg_rdata),
  .irq         (irq),
  .gen_q       (gen_q),
  .ov_q        (ov_q),
  .cnt_q       (cnt_q)
);

// File: tb/tb_pmu_monitor.sv
module tb_pmu_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] event_in = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit live = 0;

  always #5 clk = ~clk;

  pmu_monitor dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .event_in  (event_in),
    .irq       (irq)
  );

  // ---------------- reference model ----------------
  localparam bit [31:0] MASK = 32'h8000_000F;

  bit [31:0] m_cnt [4];
  bit [9:0]  m_sel [4];
  bit [47:0] m_cyc;
  bit        m_gen;
  bit        m_arm;
  bit [31:0] m_en, m_ov, m_ie;
  bit [9:0]  m_start, m_stop;
  bit        m_inc [4];
  bit        m_cinc;
  bit [31:0] m_hw, m_setv, m_clrv;
  bit        m_sh, m_ph;

  function automatic bit fires(bit [9:0] n);
    return (n != 0) && (n < 64) && event_in[n[5:0]];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
      m_cyc = 0; m_gen = 0; m_arm = 1; m_en = 0; m_ov = 0; m_ie = 0;
      m_start = 0; m_stop = 0;
    end else begin
      m_hw = 0; m_setv = 0; m_clrv = 0;
      for (int i = 0; i < 4; i++) m_inc[i] = m_gen && m_en[i] && fires(m_sel[i]);
      m_cinc = m_gen && m_en[31] && m_arm;
      m_sh = fires(m_start);
      m_ph = fires(m_stop);
      for (int i = 0; i < 4; i++) begin
        if (reg_wr && reg_addr == 10'(10'h300 + 4 * i)) m_cnt[i] = reg_wdata;
        else if (reg_wr && reg_addr == 10'h180 && reg_wdata[1]) m_cnt[i] = 0;
        else if (m_inc[i]) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) m_hw[i] = 1;
          m_cnt[i] = m_cnt[i] + 1;
        end
        if (reg_wr && reg_addr == 10'(10'h380 + 4 * i)) m_sel[i] = reg_wdata[9:0];
      end
      if (reg_wr && reg_addr == 10'h1A0) m_cyc[31:0] = reg_wdata;
      else if (reg_wr && reg_addr == 10'h1A4) m_cyc[47:32] = reg_wdata[15:0];
      else if (reg_wr && reg_addr == 10'h180 && reg_wdata[2]) m_cyc = 0;
      else if (m_cinc) begin
        if (m_cyc == 48'hFFFF_FFFF_FFFF) m_hw[31] = 1;
        m_cyc = m_cyc + 1;
      end
      if (m_ph) m_arm = 0; else if (m_sh) m_arm = 1;
      if (reg_wr) begin
        case (reg_addr)
          10'h180: m_gen = reg_wdata[0];
          10'h184: m_en = m_en | (reg_wdata & MASK);
          10'h188: m_en = m_en & ~reg_wdata;
          10'h18C: m_setv = reg_wdata;
          10'h190: m_clrv = reg_wdata;
          10'h194: m_ie = m_ie | (reg_wdata & MASK);
          10'h198: m_ie = m_ie & ~reg_wdata;
          10'h1A8: begin m_start = reg_wdata[9:0]; m_stop = reg_wdata[25:16]; end
          default: ;
        endcase
      end
      m_ov = ((m_ov & ~m_clrv) | m_setv | m_hw) & MASK;
    end
  end

  function automatic bit [31:0] mread(bit [9:0] a);
    bit [31:0] r = 0;
    case (a)
      10'h180: r = {31'b0, m_gen};
      10'h184: r = m_en;
      10'h18C: r = m_ov;
      10'h194: r = m_ie;
      10'h1A0: r = m_cyc[31:0];
      10'h1A4: r = {16'b0, m_cyc[47:32]};
      10'h1A8: r = {6'b0, m_stop, 6'b0, m_start};
      default: r = 0;
    endcase
    for (int i = 0; i < 4; i++) begin
      if (a == 10'(10'h300 + 4 * i)) r = m_cnt[i];
      if (a == 10'(10'h380 + 4 * i)) r = {22'b0, m_sel[i]};
    end
    return r;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // irq compared against the model on every clock (R6)
  always @(negedge clk) begin
    if (live && rst_n) check("R6", {31'b0, irq}, {31'b0, |(m_ov & m_ie)}, "irq level");
  end

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(logic [9:0] a, string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1;
    check(tag, reg_rdata, mread(a), $sformatf("read 0x%h", a));
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); reg_wr = 1'b0; end
  endtask

  task automatic idle_rand(int n);
    repeat (n) begin
      @(negedge clk);
      reg_wr = 1'b0;
      event_in = {$urandom, $urandom};
    end
    @(negedge clk);
    event_in = '0;
  endtask

  task automatic pulse(logic [63:0] v);
    @(negedge clk);
    reg_wr = 1'b0; event_in = v;
    @(negedge clk);
    event_in = '0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  localparam logic [9:0] ADDRS [18] = '{
    10'h180, 10'h184, 10'h188, 10'h18C, 10'h190, 10'h194, 10'h198,
    10'h1A0, 10'h1A4, 10'h1A8, 10'h300, 10'h304, 10'h308, 10'h30C,
    10'h380, 10'h384, 10'h388, 10'h38C};

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;

    // R1: reset values
    for (int k = 0; k < 18; k++) rd(ADDRS[k], "R1");
    check("R1", {31'b0, irq}, 32'h0, "irq after reset");

    // R3: enable set/clear semantics
    wr(10'h184, 32'hFFFF_FFFF);
    rd(10'h184, "R3");
    check("R3", reg_rdata, 32'h8000_000F, "implemented enable bits");
    wr(10'h188, 32'h0000_0002);
    rd(10'h184, "R3");
    wr(10'h184, 32'h0);
    rd(10'h184, "R3");
    rd(10'h188, "R3");
    wr(10'h184, 32'h0000_0002);

    // R2/R9: selectors and counting; 70 is out of range, 0 is none
    wr(10'h380, 32'd1);
    wr(10'h384, 32'd2);
    wr(10'h388, 32'd0);
    wr(10'h38C, 32'd70);
    for (int i = 0; i < 4; i++) rd(10'(10'h380 + 4 * i), "R9");
    wr(10'h180, 32'h1);
    idle_rand(40);
    for (int i = 0; i < 4; i++) rd(10'(10'h300 + 4 * i), "R2");
    // R7: cycle counter ran since reset arming
    rd(10'h1A0, "R7");
    check("R7", {31'b0, reg_rdata != 0}, 32'h1, "cycle counter advanced while armed");

    // R4: global disable and reset strobes
    wr(10'h180, 32'h0);
    idle_rand(20);
    for (int i = 0; i < 4; i++) rd(10'(10'h300 + 4 * i), "R4");
    rd(10'h1A0, "R4");
    rd(10'h180, "R4");
    wr(10'h180, 32'h7);
    rd(10'h180, "R4");
    check("R4", reg_rdata, 32'h1, "reset bits read zero");
    rd(10'h300, "R4");
    rd(10'h304, "R4");
    rd(10'h1A0, "R4");

    // R5/R6: overflow flagging and interrupt
    wr(10'h300, 32'hFFFF_FFFE);
    @(negedge clk); reg_wr = 1'b0; event_in = 64'h2;
    idle(3);
    event_in = '0;
    rd(10'h18C, "R5");
    check("R5", reg_rdata & 32'h1, 32'h1, "counter 0 wrap flagged");
    wr(10'h194, 32'h1);
    idle(2);
    check("R6", {31'b0, irq}, 32'h1, "irq with enabled overflow");
    rd(10'h194, "R6");
    wr(10'h190, 32'h1);
    idle(1);
    check("R6", {31'b0, irq}, 32'h0, "irq after clearing overflow");
    wr(10'h18C, 32'h4);
    rd(10'h18C, "R5");
    wr(10'h190, 32'h4);
    // same-cycle wrap and clear on counter 1: set wins
    wr(10'h304, 32'hFFFF_FFFF);
    wr(10'h190, 32'h2);
    event_in = 64'h4;
    @(negedge clk); reg_wr = 1'b0; event_in = '0;
    rd(10'h18C, "R5");
    check("R5", reg_rdata & 32'h2, 32'h2, "wrap beats same-cycle clear");
    wr(10'h198, 32'hFFFF_FFFF);
    rd(10'h194, "R6");

    // R7: 48-bit layout and wrap
    wr(10'h1A4, 32'h0001_2345);
    rd(10'h1A4, "R7");
    wr(10'h1A4, 32'h0000_FFFF);
    wr(10'h1A0, 32'hFFFF_FFF0);
    idle(20);
    rd(10'h18C, "R7");
    check("R7", reg_rdata & 32'h8000_0000, 32'h8000_0000, "cycle wrap flagged");
    rd(10'h1A4, "R7");
    rd(10'h1A0, "R7");

    // R8: start/stop arming
    wr(10'h1A8, 32'h0006_0005);
    rd(10'h1A8, "R8");
    pulse(64'h40);
    rd(10'h1A0, "R8");
    idle(5);
    rd(10'h1A0, "R8");
    pulse(64'h20);
    idle(4);
    rd(10'h1A0, "R8");
    pulse(64'h60);
    idle(4);
    rd(10'h1A0, "R8");
    pulse(64'h20);

    // R9: direct write beats same-cycle increment, no overflow from write
    wr(10'h190, 32'hFFFF_FFFF);
    wr(10'h300, 32'h0000_0100);
    event_in = 64'h2;
    @(negedge clk); reg_wr = 1'b0; event_in = '0;
    rd(10'h300, "R9");
    wr(10'h304, 32'hFFFF_FFFF);
    rd(10'h18C, "R9");

    // Random phase across all registers and events
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      event_in = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) begin
        logic [31:0] d;
        d = $urandom;
        if ($urandom_range(0, 2) == 0) d = 32'hFFFF_FFF0 | ($urandom & 32'hF);
        reg_wr = 1'b1;
        reg_addr = ADDRS[$urandom_range(0, 17)];
        reg_wdata = d;
      end else begin
        reg_wr = 1'b0;
        reg_addr = ADDRS[$urandom_range(0, 17)];
        #1;
        check("R2", reg_rdata, mread(reg_addr), $sformatf("random read 0x%h", reg_addr));
      end
    end
    @(negedge clk); reg_wr = 1'b0; event_in = '0;
    for (int k = 0; k < 18; k++) rd(ADDRS[k], "R9");

    summary();
    $finish;
  end

endmodule